// File: doc/BRIEF.md
# CSR Access Execution Unit

This unit carries out the six control-and-status-register instructions of a RISC-V core: the register forms (write, set, clear) and the immediate forms of each. It receives a 32-bit instruction word together with the rs1 operand value, a valid strobe and the privilege level of the hart. One cycle after the strobe it reports completion, the value the CSR held before the instruction, an rd write-enable, and an illegal-instruction flag for the trap logic.

Inside sits a small bank of read/write CSRs, each with its own mask of writable bits, plus two read-only registers: a free-running cycle counter and a fixed identification word. Whether an instruction reads, writes or both depends on its operands. A write form whose destination is x0 does not read. A set or clear form whose source field is zero does not write, so it cannot raise the fault for writing a read-only register.

Top module: `csr_exec_unit`

## Requirements
- R1: funct3 (instruction bits 14:12) is decoded as 001 write, 010 set, 011 clear, 101 write-immediate, 110 set-immediate, 111 clear-immediate. The codes 000 and 100 raise illegal-instruction.
- R2: The CSR address is taken from instruction bits 31:20. The immediate forms use bits 19:15 as an unsigned 5-bit value, zero-extended to 32 bits, and ignore the rs1 value input.
- R3: Every cycle with in_valid high yields exactly one out_done pulse on the following cycle. out_rd_we is high then only if the access is legal and rd (bits 11:7) is not zero.
- R4: A legal access returns the CSR value from before the update on out_rd_data. The write forms store the operand, the set forms store old OR operand, and the clear forms store old AND NOT operand.
- R5: Only writable bits change. The default bank has registers at 0x040 (mask FFFFFFFF), 0x141 (mask 00FFFFFF), 0x342 (mask 0000FFFF) and 0x343 (mask 000000FF), all resetting to zero.
- R6: A write form with rd = x0 performs no read: out_rd_we and out_rd_data stay zero, while the write still takes place.
- R7: A set or clear form whose rs1 field is zero performs no write, and so raises no read-only fault. The other forms always write.
- R8: An address that matches no implemented CSR raises illegal-instruction.
- R9: An address whose bits 9:8 exceed in_priv (0 user, 1 supervisor, 3 machine) raises illegal-instruction.
- R10: An address with bits 11:10 equal to 11 is read-only, and any instruction that would write it raises illegal-instruction.
- R11: On illegal-instruction no CSR changes, out_rd_we is low and out_rd_data is zero.
- R12: The counter at 0xC00 (user level) resets to 0 and increments every cycle except a cycle that carries a legal access. The ID register at 0xF11 (machine level) reads as ID_VALUE (default 5EC00001).
- R13: After reset, out_done, out_rd_we, out_illegal and out_rd_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | CSR instruction word |
| in_rs1_val | input | 32 | Value of register rs1 |
| in_priv | input | 2 | Current privilege level |
| out_done | output | 1 | One-cycle completion pulse |
| out_rd_we | output | 1 | Write rd with out_rd_data |
| out_rd_data | output | 32 | CSR value before the update |
| out_illegal | output | 1 | Illegal-instruction flag |

## Verification
The bench uses the default parameters: four read/write registers, which cover all three privilege levels and four different writable masks, plus the counter and the ID register. With this map, legal and illegal accesses, privilege failures and read-only write attempts all come up within one random run. The addresses 0x344 and 0x7C0 sit just outside the map and exercise the missing-CSR path. The counter is modelled cycle by cycle, so every read of it also checks the hold in cycles that carry a legal access.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

    localparam int XLEN   = 32;
    localparam int INSN_W = 32;
    localparam int ADDR_W = 12;
    localparam int REG_W  = 5;

    localparam logic [1:0] PRIV_USER  = 2'd0;
    localparam logic [1:0] PRIV_SUPER = 2'd1;
    localparam logic [1:0] PRIV_MACH  = 2'd3;

    typedef enum logic [1:0] {
        OPK_WRITE = 2'd0,
        OPK_SET   = 2'd1,
        OPK_CLEAR = 2'd2,
        OPK_NONE  = 2'd3
    } csr_opk_e;

    typedef struct packed {
        csr_opk_e            kind;
        logic                f3_ok;
        logic [ADDR_W-1:0]   addr;
        logic                rd_nz;
        logic                src_nz;
        logic [XLEN-1:0]     operand;
        logic                do_read;
        logic                do_write;
    } csr_dec_t;

    // privilege field of a read/write bank entry
    function automatic logic [1:0] rw_csr_level(input int idx);
        if (idx == 0)      return PRIV_USER;
        else if (idx == 1) return PRIV_SUPER;
        else               return PRIV_MACH;
    endfunction

    function automatic logic [ADDR_W-1:0] rw_csr_addr(input int idx);
        logic [7:0] low;
        low = 8'h40 + 8'(idx);
        return {2'b00, rw_csr_level(idx), low};
    endfunction

    function automatic logic [XLEN-1:0] rw_csr_mask(input int idx);
        int sh;
        sh = (idx % 4) * 8;
        return {XLEN{1'b1}} >> sh;
    endfunction

    function automatic logic csr_is_readonly(input logic [ADDR_W-1:0] a);
        return a[11:10] == 2'b11;
    endfunction

    function automatic logic [1:0] csr_min_priv(input logic [ADDR_W-1:0] a);
        return a[9:8];
    endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_exec_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    input  logic [XLEN-1:0]   rs1_val,
    output csr_dec_t          dec
);
    logic [2:0]       f3;
    logic [REG_W-1:0] rd_f;
    logic [REG_W-1:0] rs1_f;
    logic             imm_form;
    logic             unused_opcode;

    assign f3            = instr[14:12];
    assign rd_f          = instr[11:7];
    assign rs1_f         = instr[19:15];
    assign unused_opcode = ^instr[6:0];

    always_comb begin
        dec       = '0;
        imm_form  = f3[2];
        dec.addr  = instr[31:20];
        dec.rd_nz = rd_f != '0;
        dec.src_nz = rs1_f != '0;
        unique case (f3[1:0])
            2'b01:   dec.kind = OPK_WRITE;
            2'b10:   dec.kind = OPK_SET;
            2'b11:   dec.kind = OPK_CLEAR;
            default: dec.kind = OPK_NONE;
        endcase
        dec.f3_ok   = dec.kind != OPK_NONE;
        dec.operand = imm_form ? {{(XLEN-REG_W){1'b0}}, rs1_f} : rs1_val;
        dec.do_read  = (dec.kind != OPK_WRITE) || dec.rd_nz;
        dec.do_write = (dec.kind == OPK_WRITE) || dec.src_nz;
    end
endmodule

// File: rtl/csr_alu.sv
module csr_alu
    import csr_exec_pkg::*;
(
    input  csr_opk_e        kind,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] new_val
);
    always_comb begin
        unique case (kind)
            OPK_WRITE: new_val = operand;
            OPK_SET:   new_val = old_val | operand;
            OPK_CLEAR: new_val = old_val & ~operand;
            default:   new_val = old_val;
        endcase
    end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_exec_pkg::*;
#(
    parameter int              NUM_RW   = 4,
    parameter logic [XLEN-1:0] ID_VALUE = 32'h5EC0_0001,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'hC00,
    parameter logic [ADDR_W-1:0] ID_ADDR  = 12'hF11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    output logic                   hit,
    output logic [XLEN-1:0]        rd_val,
    input  logic                   wr_en,
    input  logic [XLEN-1:0]        wr_val,
    input  logic                   cnt_hold,
    output logic [NUM_RW*XLEN-1:0] rw_state,
    output logic [XLEN-1:0]        cnt_value
);
    logic [NUM_RW-1:0]   sel;
    logic [XLEN-1:0]     regs [NUM_RW];
    logic                cnt_sel;
    logic                id_sel;
    logic [XLEN-1:0]     cnt_q;

    for (genvar gi = 0; gi < NUM_RW; gi++) begin : g_rw
        localparam logic [ADDR_W-1:0] EADDR = rw_csr_addr(gi);
        localparam logic [XLEN-1:0]   EMASK = rw_csr_mask(gi);

        assign sel[gi] = addr == EADDR;

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[gi] <= '0;
            end else if (wr_en && sel[gi]) begin
                regs[gi] <= (regs[gi] & ~EMASK) | (wr_val & EMASK);
            end
        end

        assign rw_state[gi*XLEN +: XLEN] = regs[gi];
    end

    assign cnt_sel = addr == CNT_ADDR;
    assign id_sel  = addr == ID_ADDR;
    assign hit     = (|sel) || cnt_sel || id_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!cnt_hold) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
    assign cnt_value = cnt_q;

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (sel[i]) rd_val = rd_val | regs[i];
        end
        if (cnt_sel) rd_val = rd_val | cnt_q;
        if (id_sel)  rd_val = rd_val | ID_VALUE;
    end
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
    import csr_exec_pkg::*;
#(
    parameter int                NUM_RW   = 4,
    parameter logic [XLEN-1:0]   ID_VALUE = 32'h5EC0_0001,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'hC00,
    parameter logic [ADDR_W-1:0] ID_ADDR  = 12'hF11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_instr,
    input  logic [XLEN-1:0]   in_rs1_val,
    input  logic [1:0]        in_priv,
    output logic              out_done,
    output logic              out_rd_we,
    output logic [XLEN-1:0]   out_rd_data,
    output logic              out_illegal
);
    csr_dec_t                dec;
    logic                    bank_hit;
    logic [XLEN-1:0]         old_val;
    logic [XLEN-1:0]         new_val;
    logic                    priv_ok;
    logic                    ro_fault;
    logic                    legal;
    logic                    acc_ok;
    logic                    bank_we;
    logic [NUM_RW*XLEN-1:0]  rw_state;
    logic [XLEN-1:0]         cnt_value;

    csr_decode u_dec (
        .instr   (in_instr),
        .rs1_val (in_rs1_val),
        .dec     (dec)
    );

    csr_bank #(
        .NUM_RW   (NUM_RW),
        .ID_VALUE (ID_VALUE),
        .CNT_ADDR (CNT_ADDR),
        .ID_ADDR  (ID_ADDR)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .addr      (dec.addr),
        .hit       (bank_hit),
        .rd_val    (old_val),
        .wr_en     (bank_we),
        .wr_val    (new_val),
        .cnt_hold  (acc_ok),
        .rw_state  (rw_state),
        .cnt_value (cnt_value)
    );

    csr_alu u_alu (
        .kind    (dec.kind),
        .old_val (old_val),
        .operand (dec.operand),
        .new_val (new_val)
    );

    assign priv_ok  = in_priv >= csr_min_priv(dec.addr);
    assign ro_fault = csr_is_readonly(dec.addr) && dec.do_write;
    assign legal    = dec.f3_ok && bank_hit && priv_ok && !ro_fault;
    assign acc_ok   = in_valid && legal;
    assign bank_we  = acc_ok && dec.do_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_done    <= 1'b0;
            out_rd_we   <= 1'b0;
            out_rd_data <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_done    <= in_valid;
            out_rd_we   <= acc_ok && dec.rd_nz;
            out_rd_data <= (acc_ok && dec.do_read) ? old_val : '0;
            out_illegal <= in_valid && !legal;
        end
    end
endmodule

// File: rtl/csr_exec_unit_chk.sv
module csr_exec_unit_chk
    import csr_exec_pkg::*;
#(
    parameter int NUM_RW = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [INSN_W-1:0]      in_instr,
    input logic                   out_done,
    input logic                   out_rd_we,
    input logic [XLEN-1:0]        out_rd_data,
    input logic                   out_illegal,
    input logic [NUM_RW*XLEN-1:0] rw_state,
    input logic [XLEN-1:0]        cnt_value
);
    a_r3_done_follows_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);

    a_r3_no_done_without_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);

    a_r3_we_only_on_done: assert property (@(posedge clk) disable iff (rst)
        out_rd_we |-> out_done);

    a_r11_illegal_blocks_result: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_rd_we && out_rd_data == '0));

    a_r11_illegal_keeps_state: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> rw_state == $past(rw_state));

    a_r6_write_form_rd0_no_read: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[13:12] == 2'b01 && in_instr[11:7] == 5'd0)
        |=> (!out_rd_we && out_rd_data == '0));

    a_r7_zero_source_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[13] && in_instr[19:15] == 5'd0)
        |=> rw_state == $past(rw_state));

    a_r12_counter_runs_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> cnt_value == $past(cnt_value) + 1'b1);

    a_r12_counter_holds_on_access: assert property (@(posedge clk) disable iff (rst)
        (out_done && !out_illegal) |-> cnt_value == $past(cnt_value));
endmodule

bind csr_exec_unit csr_exec_unit_chk #(.NUM_RW(NUM_RW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .out_done    (out_done),
    .out_rd_we   (out_rd_we),
    .out_rd_data (out_rd_data),
    .out_illegal (out_illegal),
    .rw_state    (rw_state),
    .cnt_value   (cnt_value)
);

// File: tb/csr_exec_unit_test.sv
module csr_exec_unit_test;

    localparam logic [31:0] ID_V = 32'h5EC0_0001;
    localparam logic [11:0] A_CNT = 12'hC00;
    localparam logic [11:0] A_ID  = 12'hF11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_rs1_val = '0;
    logic [1:0]  in_priv = 2'd3;
    logic        out_done;
    logic        out_rd_we;
    logic [31:0] out_rd_data;
    logic        out_illegal;

    int n_checks = 0;
    int n_fail   = 0;

    logic        tb_legal = 1'b0;
    logic [31:0] m_rw [4];
    logic [31:0] m_cnt;

    csr_exec_unit uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_instr    (in_instr),
        .in_rs1_val  (in_rs1_val),
        .in_priv     (in_priv),
        .out_done    (out_done),
        .out_rd_we   (out_rd_we),
        .out_rd_data (out_rd_data),
        .out_illegal (out_illegal)
    );

    always #10 clk = ~clk;

    // counter model per R12
    always @(posedge clk) begin
        if (rst) m_cnt <= '0;
        else if (!(in_valid && tb_legal)) m_cnt <= m_cnt + 1;
    end

    function automatic logic [11:0] b_addr(input int i);
        case (i)
            0: return 12'h040;
            1: return 12'h141;
            2: return 12'h342;
            default: return 12'h343;
        endcase
    endfunction

    function automatic logic [31:0] b_mask(input int i);
        case (i)
            0: return 32'hFFFF_FFFF;
            1: return 32'h00FF_FFFF;
            2: return 32'h0000_FFFF;
            default: return 32'h0000_00FF;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] f3, input logic [4:0] rd,
                          input logic [4:0] rs1f, input logic [11:0] csr,
                          input logic [31:0] rv, input logic [1:0] pv,
                          input string tag);
        int idx;
        logic ex, f3ok, wr, ro, legal, rdv;
        logic [31:0] old, opnd, nv;
        idx = -1;
        for (int i = 0; i < 4; i++) if (csr == b_addr(i)) idx = i;
        @(negedge clk);
        ex    = (idx >= 0) || csr == A_CNT || csr == A_ID;
        old   = (idx >= 0) ? m_rw[idx] : (csr == A_CNT) ? m_cnt : (csr == A_ID) ? ID_V : 32'h0;
        f3ok  = f3 != 3'b000 && f3 != 3'b100;
        wr    = (f3[1:0] == 2'b01) || rs1f != 5'd0;
        ro    = csr[11:10] == 2'b11;
        legal = f3ok && ex && (pv >= csr[9:8]) && !(ro && wr);
        rdv   = (f3[1:0] != 2'b01) || rd != 5'd0;
        opnd  = f3[2] ? {27'b0, rs1f} : rv;
        case (f3[1:0])
            2'b01:   nv = opnd;
            2'b10:   nv = old | opnd;
            2'b11:   nv = old & ~opnd;
            default: nv = old;
        endcase
        in_instr   = {csr, rs1f, f3, rd, 7'b1110011};
        in_rs1_val = rv;
        in_priv    = pv;
        in_valid   = 1'b1;
        tb_legal   = legal;
        @(negedge clk);
        in_valid = 1'b0;
        tb_legal = 1'b0;
        check(tag, "done", {31'b0, out_done}, 32'd1);
        check(tag, "illegal", {31'b0, out_illegal}, {31'b0, !legal});
        check(tag, "rd_we", {31'b0, out_rd_we}, {31'b0, legal && rd != 5'd0});
        check(tag, "rd_data", out_rd_data, (legal && rdv) ? old : 32'h0);
        if (legal && wr && idx >= 0)
            m_rw[idx] = (m_rw[idx] & ~b_mask(idx)) | (nv & b_mask(idx));
    endtask

    task automatic readback(input int i, input string tag);
        access(3'b010, 5'd1, 5'd0, b_addr(i), 32'h0, 2'd3, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [11:0] pick [8];
        logic [1:0]  privs [3];
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_rw[i] = '0;
        pick[0] = 12'h040; pick[1] = 12'h141; pick[2] = 12'h342; pick[3] = 12'h343;
        pick[4] = A_CNT;   pick[5] = A_ID;    pick[6] = 12'h7C0; pick[7] = 12'h344;
        privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        check("R13", "done", {31'b0, out_done}, 32'd0);
        check("R13", "rd_we", {31'b0, out_rd_we}, 32'd0);
        check("R13", "illegal", {31'b0, out_illegal}, 32'd0);
        check("R13", "rd_data", out_rd_data, 32'd0);
        readback(3, "R5");

        // R4 write, set, clear on the full-width register
        access(3'b001, 5'd5, 5'd7, 12'h040, 32'hDEAD_BEEF, 2'd3, "R4");
        readback(0, "R4");
        access(3'b010, 5'd5, 5'd7, 12'h040, 32'h0000_00F0, 2'd0, "R4");
        access(3'b011, 5'd5, 5'd7, 12'h040, 32'hFF00_0000, 2'd0, "R4");
        readback(0, "R4");
        // R3 done falls one cycle later
        @(negedge clk);
        check("R3", "done_low", {31'b0, out_done}, 32'd0);

        // R5 masked writes
        access(3'b001, 5'd2, 5'd3, 12'h343, 32'hFFFF_FFFF, 2'd3, "R5");
        readback(3, "R5");
        access(3'b010, 5'd2, 5'd3, 12'h141, 32'hFFFF_FFFF, 2'd3, "R5");
        readback(1, "R5");

        // R2 immediate forms ignore rs1 value
        access(3'b101, 5'd4, 5'd31, 12'h342, 32'hFFFF_FFFF, 2'd3, "R2");
        readback(2, "R2");
        access(3'b111, 5'd4, 5'd5, 12'h342, 32'hFFFF_FFFF, 2'd3, "R2");
        access(3'b110, 5'd4, 5'd0, 12'h342, 32'hFFFF_FFFF, 2'd3, "R2");
        readback(2, "R2");

        // R6 write form rd=x0: no read, write still done
        access(3'b001, 5'd0, 5'd9, 12'h040, 32'h1234_5678, 2'd3, "R6");
        access(3'b101, 5'd0, 5'd3, 12'h343, 32'h0, 2'd3, "R6");
        readback(0, "R6");
        readback(3, "R6");

        // R7 zero source field: no write, no read-only fault
        access(3'b010, 5'd6, 5'd0, A_CNT, 32'hFFFF_FFFF, 2'd0, "R7");
        access(3'b111, 5'd6, 5'd0, A_ID, 32'h0, 2'd3, "R7");
        access(3'b011, 5'd6, 5'd0, 12'h040, 32'hFFFF_FFFF, 2'd3, "R7");
        readback(0, "R7");

        // R10 actual writes to read-only registers
        access(3'b010, 5'd6, 5'd1, A_CNT, 32'h0, 2'd3, "R10");
        access(3'b101, 5'd0, 5'd4, A_ID, 32'h0, 2'd3, "R10");

        // R8 missing addresses
        access(3'b010, 5'd6, 5'd0, 12'h7C0, 32'h0, 2'd3, "R8");
        access(3'b001, 5'd6, 5'd2, 12'h344, 32'h55, 2'd3, "R8");

        // R9 privilege
        access(3'b001, 5'd6, 5'd2, 12'h342, 32'hAAAA, 2'd1, "R9");
        access(3'b001, 5'd6, 5'd2, 12'h141, 32'hAAAA, 2'd1, "R9");
        access(3'b001, 5'd6, 5'd2, 12'h141, 32'h5555, 2'd0, "R9");
        access(3'b010, 5'd6, 5'd0, A_ID, 32'h0, 2'd1, "R9");
        readback(1, "R11");
        readback(2, "R11");

        // R1 unused funct3 codes
        access(3'b000, 5'd6, 5'd2, 12'h040, 32'hFFFF, 2'd3, "R1");
        access(3'b100, 5'd6, 5'd2, 12'h040, 32'hFFFF, 2'd3, "R1");
        readback(0, "R11");

        // R12 counter across idle gaps and the ID value
        access(3'b010, 5'd8, 5'd0, A_CNT, 32'h0, 2'd0, "R12");
        repeat (7) @(posedge clk);
        access(3'b010, 5'd8, 5'd0, A_CNT, 32'h0, 2'd0, "R12");
        access(3'b011, 5'd8, 5'd0, A_ID, 32'h0, 2'd3, "R12");

        // constrained random mix
        for (int k = 0; k < 300; k++) begin
            logic [2:0]  f3;
            logic [4:0]  rd, rs;
            f3 = 3'($urandom % 8);
            rd = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            rs = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            access(f3, rd, rs, pick[$urandom % 8], $urandom,
                   privs[$urandom % 3], "R4");
        end
        for (int i = 0; i < 4; i++) readback(i, "R5");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule